// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block behaves as a small serial EEPROM on a two-wire (I2C) bus. A fast system clock oversamples the clock line and the data line through two-flop synchronizers. The block finds bus START and STOP conditions on the synchronized lines. It answers only to a fixed device-type code. It drives the data line as an open-drain output: `sda_oe` high pulls the wire low, and low releases it. Storage is a register array of `MEM_DEPTH` bytes, 16 by default. Only the low address bits of the word address are used.

A write has three bytes: the device byte with the direction bit 0, a word address that is loaded into the address pointer, and one data byte. The byte is committed only on the STOP that follows that full sequence. A busy counter then models the programming time, and for its length the block ignores the bus. A read returns the byte at the pointer, MSB first. The master sends an ACK to get the next byte, and the pointer increments after each byte. A master NACK ends the transfer. After a write, the pointer stays on the location just written, so a read that follows returns that byte.

The controller states are:

| State | Meaning |
|---|---|
| ST_IDLE | Waiting for a START |
| ST_DEV | Receiving the device byte |
| ST_DEV_ACK | Ninth clock of the device byte |
| ST_WADDR | Receiving the word address |
| ST_WADDR_ACK | Ninth clock of the word address |
| ST_WDATA | Receiving the data byte |
| ST_WDATA_ACK | Ninth clock of the data byte |
| ST_WAIT_STOP | Write armed; waiting for STOP |
| ST_RD_BIT | Shifting a byte out |
| ST_RD_ACK | Sampling the master's acknowledge |
| ST_IGNORE | Deselected until the next START or STOP |

The transitions are:
- START moves any state to ST_DEV.
- STOP moves any state to ST_IDLE, and from ST_WAIT_STOP it also commits the write.
- Programming time forces ST_IDLE.
- ST_DEV goes to ST_DEV_ACK on a match, or to ST_IGNORE otherwise.
- ST_DEV_ACK goes to ST_RD_BIT for a read, or to ST_WADDR for a write.
- On a write, ST_WADDR, ST_WADDR_ACK, ST_WDATA and ST_WDATA_ACK follow in that order, and ST_WDATA_ACK leads to ST_WAIT_STOP.
- On a read, ST_RD_BIT goes to ST_RD_ACK.
- ST_RD_ACK goes to ST_RD_BIT on an ACK, or to ST_IGNORE on a NACK.

Bits are sampled on rising edges of the synchronized clock line. `sda_oe` changes only after a falling edge.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset, and before any START (SDA falling while SCL is high), `sda_oe` is 0 and clocked bytes get no acknowledge.
- R2: A STOP (SDA rising while SCL is high) returns the block to idle: `sda_oe` is 0 and later bytes without a START get no acknowledge.
- R3: A device byte whose bits 7:4 equal 1010 is acknowledged by holding SDA low in the ninth clock, whatever bits 3:1 hold. Bit 0 selects the direction: 1 is read and 0 is write.
- R4: A device byte whose bits 7:4 differ from 1010 gets no acknowledge, and neither does any byte after it until the next START.
- R5: In a write, the device byte, the word address and the data byte are each acknowledged. The low 4 bits of the word address load the address pointer.
- R6: A STOP after the acknowledged data byte writes that byte to the addressed location and starts a programming interval of `PROG_CYCLES` system clocks.
- R7: A STOP that comes before the data byte is complete leaves memory unchanged and starts no programming interval, so the block answers a new START at once.
- R8: During the programming interval the block never drives SDA, and it does not acknowledge even a matching device byte.
- R9: After a write, the address pointer stays on the written location, so a following read returns the byte just written.
- R10: A read sends the byte at the pointer MSB first. The pointer then increments and wraps from 15 to 0, and a master ACK (SDA low in the ninth clock) brings the next byte.
- R11: A master NACK (SDA high in the ninth clock) ends the read, and SDA stays released for any further clocks until START or STOP.
- R12: Apart from the cycle after a START, STOP or programming event, `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Device codes are applied in several forms: an exact match, a match with the don't-care bits set, and a code that differs in the high nibble. These show that the match looks only at bits 7:4.

Writes are tried in three ways:
- a complete write;
- a write cut short by a STOP in the middle of the data byte;
- a write followed at once by a new request.

Together these separate a committed write, an aborted write and the programming-time lockout.

Reads are tried in three ways:
- a current-address read right after a write, which shows that the pointer stays on the written location;
- a sequential read across the 15-to-0 boundary, using a value that is not bit-symmetric so that the bit order is exposed;
- extra clocks after a NACK, which show that the line is released.

// File: rtl/eei2c_pkg.sv
package eei2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_WAIT_STOP,
        ST_RD_BIT,
        ST_RD_ACK,
        ST_IGNORE
    } slv_state_e;

endpackage

// File: rtl/bus_sync_detect.sv
module bus_sync_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_sh[SYNC_STAGES-1];
            sda_q  <= sda_sh[SYNC_STAGES-1];
        end
    end

    assign scl_lvl   = scl_sh[SYNC_STAGES-1];
    assign sda_lvl   = sda_sh[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/byte_store.sv
module byte_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[g] <= '0;
            end else if (we && (waddr == AW'(g))) begin
                cells[g] <= wdata;
            end
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int CYCLES = 64,
    localparam int TW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);

    logic [TW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (kick) begin
            remain <= TW'(CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
    import eei2c_pkg::*;
#(
    parameter int         MEM_DEPTH   = 16,
    parameter int         PROG_CYCLES = 64,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    localparam int AW = $clog2(MEM_DEPTH);
    localparam int BW = 8;
    localparam int CW = $clog2(BW + 1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic busy, mem_we, dev_match, dir_read, master_ack;

    slv_state_e    state, nxt;
    logic [CW-1:0] bit_cnt;
    logic [BW-1:0] rx_sh;
    logic [BW-1:0] tx_sh;
    logic [BW-1:0] wr_buf;
    logic [BW-1:0] rd_byte;
    logic [AW-1:0] ptr;
    logic          byte_done;

    bus_sync_detect #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    byte_store #(.DEPTH(MEM_DEPTH), .DW(BW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (ptr),
        .wdata (wr_buf),
        .raddr (ptr),
        .rdata (rd_byte)
    );

    prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (mem_we),
        .busy  (busy)
    );

    assign dev_match = (rx_sh[BW-1:BW-4] == DEV_TYPE);
    assign dir_read  = rx_sh[0];
    assign byte_done = scl_fall && (bit_cnt == CW'(BW));
    assign mem_we    = !busy && stop_det && (state == ST_WAIT_STOP);

    // next-state decode
    always_comb begin
        nxt = state;
        if (busy) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_DEV;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_DEV:       if (byte_done) nxt = dev_match ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK:   if (scl_fall)  nxt = dir_read ? ST_RD_BIT : ST_WADDR;
                ST_WADDR:     if (byte_done) nxt = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall)  nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  nxt = ST_WAIT_STOP;
                ST_WAIT_STOP: nxt = ST_WAIT_STOP;
                ST_RD_BIT:    if (byte_done) nxt = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall)  nxt = master_ack ? ST_RD_BIT : ST_IGNORE;
                ST_IGNORE:    nxt = ST_IGNORE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe     <= 1'b0;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            wr_buf     <= '0;
            ptr        <= '0;
            master_ack <= 1'b0;
        end else if (busy) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
        end else if (start_det) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
        end else if (stop_det) begin
            sda_oe  <= 1'b0;
        end else if (scl_rise) begin
            case (state)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    rx_sh   <= {rx_sh[BW-2:0], sda_lvl};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                ST_RD_BIT: bit_cnt    <= bit_cnt + 1'b1;
                ST_RD_ACK: master_ack <= ~sda_lvl;
                default: ;
            endcase
        end else if (scl_fall) begin
            case (state)
                ST_DEV: begin
                    if (bit_cnt == CW'(BW)) sda_oe <= dev_match;
                end
                ST_DEV_ACK: begin
                    bit_cnt <= '0;
                    if (dir_read) begin
                        tx_sh  <= rd_byte;
                        sda_oe <= ~rd_byte[BW-1];
                    end else begin
                        sda_oe <= 1'b0;
                    end
                end
                ST_WADDR: begin
                    if (bit_cnt == CW'(BW)) begin
                        sda_oe <= 1'b1;
                        ptr    <= rx_sh[AW-1:0];
                    end
                end
                ST_WADDR_ACK: begin
                    sda_oe  <= 1'b0;
                    bit_cnt <= '0;
                end
                ST_WDATA: begin
                    if (bit_cnt == CW'(BW)) begin
                        sda_oe <= 1'b1;
                        wr_buf <= rx_sh;
                    end
                end
                ST_WDATA_ACK: sda_oe <= 1'b0;
                ST_RD_BIT: begin
                    if (bit_cnt == CW'(BW)) begin
                        sda_oe <= 1'b0;
                        ptr    <= ptr + 1'b1;
                    end else begin
                        sda_oe <= ~tx_sh[BW-2];
                        tx_sh  <= {tx_sh[BW-2:0], 1'b0};
                    end
                end
                ST_RD_ACK: begin
                    bit_cnt <= '0;
                    if (master_ack) begin
                        tx_sh  <= rd_byte;
                        sda_oe <= ~rd_byte[BW-1];
                    end else begin
                        sda_oe <= 1'b0;
                    end
                end
                default: sda_oe <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/eeprom_i2c_checks.sv
module eeprom_i2c_checks
    import eei2c_pkg::*;
#(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sda_oe,
    input logic          scl_lvl,
    input logic          start_det,
    input logic          stop_det,
    input logic          busy,
    input logic          mem_we,
    input logic [AW-1:0] ptr,
    input slv_state_e    state
);

    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    p_mismatch_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe);

    p_commit_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> busy);

    p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    p_ptr_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> $stable(ptr));

    p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det) && !$past(busy))
        |-> !scl_lvl);

endmodule

bind eeprom_i2c_slave eeprom_i2c_checks #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .scl_lvl   (scl_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .busy      (busy),
    .mem_we    (mem_we),
    .ptr       (ptr),
    .state     (state)
);

// File: tb/eeprom_i2c_slave_bench.sv
`timescale 1ns/1ps
module eeprom_i2c_slave_bench;

    localparam int Q    = 10;
    localparam int PROG = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    eeprom_i2c_slave #(.PROG_CYCLES(PROG)) u_eeprom_i2c_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    int vectors = 0;
    int fails   = 0;
    int r12_viol = 0;
    bit done    = 0;
    logic prev_oe = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && got_q.size() > 0) begin
                logic [7:0] e;
                logic [7:0] g;
                string t;
                e = exp_q.pop_front();
                g = got_q.pop_front();
                t = tag_q.pop_front();
                vectors++;
                if (e !== g) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", t, g, e);
                end
            end
        end
    end

    // R12 watcher: SDA drive changes only while SCL low
    always @(posedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && scl) r12_viol++;
        prev_oe <= sda_oe;
    end

    task automatic expect_item(input string t, input logic [7:0] e);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic observe(input logic [7:0] g);
        got_q.push_back(g);
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl = 1'b1;   wq();
        sda_m = 1'b0; wq();
        scl = 1'b0;   wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl = 1'b1;   wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, input string t, input logic exp_ack);
        logic ack;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl = 1'b1;   wq(); wq();
            scl = 1'b0;   wq();
        end
        sda_m = 1'b1; wq();
        scl = 1'b1;   wq();
        ack = ~sda_line;
        wq();
        scl = 1'b0;   wq();
        expect_item(t, {7'd0, exp_ack});
        observe({7'd0, ack});
    endtask

    task automatic send_bits_ones(input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = 1'b1; wq();
            scl = 1'b1;   wq(); wq();
            scl = 1'b0;   wq();
        end
    endtask

    task automatic recv_byte(input logic give_ack, input string t, input logic [7:0] e);
        logic [7:0] b;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl = 1'b1; wq();
            b[i] = sda_line;
            wq();
            scl = 1'b0; wq();
        end
        sda_m = give_ack ? 1'b0 : 1'b1; wq();
        scl = 1'b1; wq(); wq();
        scl = 1'b0; wq();
        sda_m = 1'b1;
        expect_item(t, e);
        observe(b);
    endtask

    task automatic full_write(input logic [7:0] dev, input logic [7:0] wa,
                              input logic [7:0] d);
        bus_start();
        send_byte(dev, "R3 device ack", 1'b1);
        send_byte(wa,  "R5 word ack", 1'b1);
        send_byte(d,   "R5 data ack", 1'b1);
        bus_stop();
    endtask

    task automatic settle();
        repeat (PROG + 200) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state and no response before START
        expect_item("R1 reset sda_oe", 8'h00);
        observe({7'd0, sda_oe});
        scl = 1'b0; wq();
        send_byte(8'hA0, "R1 no START", 1'b0);
        bus_stop();

        // R5/R6 committed writes
        full_write(8'hA0, 8'h03, 8'h5A); settle();
        full_write(8'hA0, 8'h00, 8'h12); settle();

        // R8: request during programming is ignored
        full_write(8'hA0, 8'h07, 8'h11);
        bus_start();
        send_byte(8'hA1, "R8 busy no ack", 1'b0);
        bus_stop();
        settle();

        // R9: current-address read returns the byte just written
        bus_start();
        send_byte(8'hA1, "R3 read ack", 1'b1);
        recv_byte(1'b0, "R9 pointer held", 8'h11);
        bus_stop();

        // R3: don't-care bits set
        full_write(8'hAE, 8'h0F, 8'hC3); settle();

        // R4: mismatching device codes
        bus_start();
        send_byte(8'hB0, "R4 mismatch", 1'b0);
        send_byte(8'h00, "R4 stays deselected", 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'h20, "R4 high nibble", 1'b0);
        bus_stop();

        // R2: after STOP, bytes without START are ignored
        expect_item("R2 released after stop", 8'h00);
        observe({7'd0, sda_oe});
        scl = 1'b0; wq();
        send_byte(8'hA0, "R2 idle after stop", 1'b0);
        bus_stop();

        // R7: abort in the middle of the data byte
        bus_start();
        send_byte(8'hA0, "R5 device ack", 1'b1);
        send_byte(8'h03, "R5 word ack", 1'b1);
        send_bits_ones(4);
        bus_stop();
        bus_start();
        send_byte(8'hA1, "R7 no programming after abort", 1'b1);
        recv_byte(1'b0, "R7 memory unchanged", 8'h5A);
        bus_stop();

        // R10: sequential read across wrap, R11: NACK releases line
        bus_start();
        send_byte(8'hA0, "R5 device ack", 1'b1);
        send_byte(8'h0E, "R5 word ack", 1'b1);
        bus_start();
        send_byte(8'hA1, "R3 read ack", 1'b1);
        recv_byte(1'b1, "R10 addr 14", 8'h00);
        recv_byte(1'b1, "R10 addr 15", 8'hC3);
        recv_byte(1'b1, "R10 wrap to 0 msb first", 8'h12);
        recv_byte(1'b0, "R10 addr 1", 8'h00);
        recv_byte(1'b0, "R11 released after nack", 8'hFF);
        bus_stop();

        // R12 summary of the watcher
        expect_item("R12 drive change while scl high", 8'h00);
        observe(r12_viol[7:0]);

        repeat (5) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule